// File: doc/BRIEF.md
# Transmit Packet DMA Sequencer

This block runs the transmit side of a packet DMA engine placed between an Ethernet-style MAC and a shared packet memory. When transmission is enabled and the queue of pending transmit packet numbers holds an entry, the block latches the packet number at the head of that queue. It then starts the MAC and turns each data request from the MAC into one arbitrated memory read. The read address comes from a byte counter that belongs to the transmit side only.

When the MAC reports a collision, the block reloads the address counter and restarts the frame. It stops retrying once the sixteenth attempt has also collided. After the frame ends, whether it succeeded or failed, the block writes a status word into the head of the packet buffer. It then retires the packet in one of two ways. It can push the packet number into a completion queue in the same cycle as it pops the transmit queue. Or, when automatic release is on and the frame succeeded, it asks the memory manager to free the buffer, and the completion queue is never written.

The MAC, the memory arbiter and the memory manager sit outside the block. They connect through plain request/acknowledge signals.

Top module: `txDmaSeq`

## Requirements
- R1: The block leaves idle and pulses `macStart` for one cycle only when `txEnable` and `qNotEmpty` are both 1. If either is 0, it issues no start and no memory request.
- R2: In every attempt, the first read address is DATA_OFS (default 4). Each granted read moves the address up by ADDR_STEP (default 2), and the address wraps modulo 2^ADDR_W (default 11 bits).
- R3: A memory request, once raised, stays high with a stable address, write flag and packet number until `memGrant` arrives. Only one request is outstanding at a time. `macRdAck` is 1 in exactly the cycle in which a read is granted.
- R4: A collision during attempts 1 to 15 starts a new attempt, with a fresh `macStart` and the address reloaded. A collision during attempt 16 ends the frame as a failure.
- R5: When a frame ends, the block issues one write to address 0 with `memWe`=1. The data word has bit 15 = success, bit 14 = excessive collisions, bits 4:0 = number of attempts made, and every other bit 0.
- R6: If `autoRelease` is 1 and the frame succeeded, `relReq` goes high with `relPkt` equal to the packet number and stays high until `relAck`. `qPop` is 1 in the acknowledge cycle, and `cqPush` stays 0.
- R7: In every other case, `cqPush` and `qPop` are 1 together for exactly one cycle, with `cqPkt` equal to the packet number, and `relReq` stays 0.
- R8: The packet number is captured at start. `memPkt`, `cqPkt` and `relPkt` keep that value even if `qHeadPkt` changes afterwards.
- R9: A completion reported with `macOk`=0 gives a status with success 0 and excessive-collision flag 0, and the packet goes to the completion queue even when `autoRelease` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmit enable control bit |
| autoRelease | input | 1 | Free buffer after a good frame instead of reporting it |
| qNotEmpty | input | 1 | Transmit packet-number queue holds an entry |
| qHeadPkt | input | PKT_W | Packet number at the head of the transmit queue |
| qPop | output | 1 | Pop the head of the transmit queue |
| macStart | output | 1 | One-cycle start of a transmit attempt |
| macRdReq | input | 1 | MAC asks for the next data word |
| macRdAck | output | 1 | Requested word has been granted by the arbiter |
| macColl | input | 1 | Collision pulse from the MAC |
| macDone | input | 1 | Frame completion pulse from the MAC |
| macOk | input | 1 | Frame outcome, valid with macDone |
| memReq | output | 1 | Memory access request to the arbiter |
| memWe | output | 1 | 1 for the status write, 0 for data reads |
| memAddr | output | ADDR_W | Byte address inside the packet buffer |
| memWdata | output | DATA_W | Status word for the write access |
| memPkt | output | PKT_W | Packet number that selects the buffer |
| memGrant | input | 1 | Arbiter grant of the pending request |
| cqPush | output | 1 | Push the packet number into the completion queue |
| cqPkt | output | PKT_W | Packet number for the completion queue |
| relReq | output | 1 | Release request to the memory manager |
| relPkt | output | PKT_W | Packet number to be released |
| relAck | input | 1 | Memory manager accepted the release |

## Verification
The bench keeps the default parameters: 11-bit addresses, 6-bit packet numbers, 16-bit data and a limit of 16 attempts. It sweeps every collision count from 0 to 16 against both settings of automatic release and both frame outcomes. That sweep reaches the last permitted retry and the exhaustion at the sixteenth attempt. Grant latency and the number of reads per attempt vary across the sweep. One long frame of 1100 reads drives the 11-bit address counter past its wrap point.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_RUN,
    ST_RDWAIT,
    ST_STATUS,
    ST_RELEASE,
    ST_RETIRE
  } seqState_t;

  typedef struct packed {
    logic capPkt;
    logic clrAttempt;
    logic loadAddr;
    logic incAddr;
    logic incAttempt;
    logic latchOk;
    logic latchXs;
    logic selStatus;
  } seqStrobe_t;

endpackage

// File: rtl/txDmaDatapath.sv
module txDmaDatapath
  import txdma_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PKT_W     = 6,
  parameter int DATA_W    = 16,
  parameter int MAX_TRIES = 16,
  parameter int DATA_OFS  = 4,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [PKT_W-1:0]  qHeadPkt,
  input  logic              macOk,
  output logic [PKT_W-1:0]  pktOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] wdataOut,
  output logic              resultOk,
  output logic              lastTry
);

  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(ADDR_STEP);
  localparam logic [TRY_W-1:0]  TRY_LIMIT  = TRY_W'(MAX_TRIES);

  logic [PKT_W-1:0]  pktQ;
  logic [ADDR_W-1:0] addrQ;
  logic [TRY_W-1:0]  triesQ;
  logic              okQ;
  logic              xsQ;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktQ   <= '0;
      addrQ  <= '0;
      triesQ <= '0;
      okQ    <= 1'b0;
      xsQ    <= 1'b0;
    end else begin
      if (stb.capPkt) begin
        pktQ <= qHeadPkt;
        okQ  <= 1'b0;
        xsQ  <= 1'b0;
      end
      if (stb.clrAttempt)      triesQ <= '0;
      else if (stb.incAttempt) triesQ <= triesQ + 1'b1;
      if (stb.loadAddr)        addrQ <= START_ADDR;
      else if (stb.incAddr)    addrQ <= addrQ + STEP;
      if (stb.latchOk) begin
        okQ <= macOk;
        xsQ <= 1'b0;
      end else if (stb.latchXs) begin
        okQ <= 1'b0;
        xsQ <= 1'b1;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[DATA_W-1] = okQ;
    statusWord[DATA_W-2] = xsQ;
    statusWord[TRY_W-1:0] = triesQ;
  end

  assign pktOut   = pktQ;
  assign addrOut  = stb.selStatus ? '0 : addrQ;
  assign wdataOut = stb.selStatus ? statusWord : '0;
  assign resultOk = okQ;
  assign lastTry  = (triesQ >= TRY_LIMIT);

  // R4
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    triesQ <= TRY_LIMIT);

  // R2
  addr_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadAddr |=> addrQ == START_ADDR);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incAddr && !stb.loadAddr) |=> addrQ == $past(addrQ) + STEP);

endmodule

// File: rtl/txDmaCtrl.sv
module txDmaCtrl
  import txdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       autoRelease,
  input  logic       qNotEmpty,
  input  logic       macRdReq,
  input  logic       macColl,
  input  logic       macDone,
  input  logic       memGrant,
  input  logic       relAck,
  input  logic       resultOk,
  input  logic       lastTry,
  output seqStrobe_t stb,
  output logic       macStart,
  output logic       macRdAck,
  output logic       memReq,
  output logic       memWe,
  output logic       qPop,
  output logic       cqPush,
  output logic       relReq
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    stb      = '0;
    macStart = 1'b0;
    macRdAck = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    qPop     = 1'b0;
    cqPush   = 1'b0;
    relReq   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (txEnable && qNotEmpty) begin
          stb.capPkt     = 1'b1;
          stb.clrAttempt = 1'b1;
          stateD         = ST_LAUNCH;
        end
      end
      ST_LAUNCH: begin
        macStart       = 1'b1;
        stb.loadAddr   = 1'b1;
        stb.incAttempt = 1'b1;
        stateD         = ST_RUN;
      end
      ST_RUN: begin
        if (macColl) begin
          if (lastTry) begin
            stb.latchXs = 1'b1;
            stateD      = ST_STATUS;
          end else begin
            stateD = ST_LAUNCH;
          end
        end else if (macDone) begin
          stb.latchOk = 1'b1;
          stateD      = ST_STATUS;
        end else if (macRdReq) begin
          stateD = ST_RDWAIT;
        end
      end
      ST_RDWAIT: begin
        memReq = 1'b1;
        if (memGrant) begin
          stb.incAddr = 1'b1;
          macRdAck    = 1'b1;
          stateD      = ST_RUN;
        end
      end
      ST_STATUS: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        stb.selStatus = 1'b1;
        if (memGrant)
          stateD = (autoRelease && resultOk) ? ST_RELEASE : ST_RETIRE;
      end
      ST_RELEASE: begin
        relReq = 1'b1;
        if (relAck) begin
          qPop   = 1'b1;
          stateD = ST_IDLE;
        end
      end
      ST_RETIRE: begin
        qPop   = 1'b1;
        cqPush = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !(txEnable && qNotEmpty)) |=> stateQ == ST_IDLE);

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    macStart |=> !macStart);

  // R7
  push_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    cqPush |-> (qPop && !relReq));

  // R6
  release_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (relReq && !relAck) |=> relReq);

  // R6
  release_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (relReq && relAck) |-> (qPop && !cqPush));

endmodule

// File: rtl/txDmaSeq.sv
module txDmaSeq
  import txdma_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PKT_W     = 6,
  parameter int DATA_W    = 16,
  parameter int MAX_TRIES = 16,
  parameter int DATA_OFS  = 4,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              autoRelease,
  input  logic              qNotEmpty,
  input  logic [PKT_W-1:0]  qHeadPkt,
  output logic              qPop,
  output logic              macStart,
  input  logic              macRdReq,
  output logic              macRdAck,
  input  logic              macColl,
  input  logic              macDone,
  input  logic              macOk,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [PKT_W-1:0]  memPkt,
  input  logic              memGrant,
  output logic              cqPush,
  output logic [PKT_W-1:0]  cqPkt,
  output logic              relReq,
  output logic [PKT_W-1:0]  relPkt,
  input  logic              relAck
);

  seqStrobe_t       stb;
  logic             resultOk;
  logic             lastTry;
  logic [PKT_W-1:0] pktNum;

  txDmaCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .txEnable(txEnable), .autoRelease(autoRelease), .qNotEmpty(qNotEmpty),
    .macRdReq(macRdReq), .macColl(macColl), .macDone(macDone),
    .memGrant(memGrant), .relAck(relAck),
    .resultOk(resultOk), .lastTry(lastTry),
    .stb(stb), .macStart(macStart), .macRdAck(macRdAck),
    .memReq(memReq), .memWe(memWe), .qPop(qPop),
    .cqPush(cqPush), .relReq(relReq)
  );

  txDmaDatapath #(
    .ADDR_W(ADDR_W), .PKT_W(PKT_W), .DATA_W(DATA_W),
    .MAX_TRIES(MAX_TRIES), .DATA_OFS(DATA_OFS), .ADDR_STEP(ADDR_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .qHeadPkt(qHeadPkt), .macOk(macOk),
    .pktOut(pktNum), .addrOut(memAddr), .wdataOut(memWdata),
    .resultOk(resultOk), .lastTry(lastTry)
  );

  assign memPkt = pktNum;
  assign cqPkt  = pktNum;
  assign relPkt = pktNum;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGrant) |=> (memReq && $stable(memAddr) && $stable(memWe)
                               && $stable(memPkt)));

  // R3
  ack_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    macRdAck |-> (memReq && memGrant && !memWe));

  // R8
  pkt_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || relReq) |=> $stable(memPkt) || macStart || $past(!memReq && !relReq));

endmodule

// File: tb/txDmaSeq_tb.sv
`timescale 1ns/1ps
module txDmaSeq_tb;

  localparam int ADDR_W = 11;
  localparam int PKT_W  = 6;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b0, autoRelease = 1'b0, qNotEmpty = 1'b0;
  logic [PKT_W-1:0] qHeadPkt = '0;
  logic qPop, macStart, macRdAck;
  logic macRdReq = 1'b0, macColl = 1'b0, macDone = 1'b0, macOk = 1'b0;
  logic memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [PKT_W-1:0] memPkt, cqPkt, relPkt;
  logic memGrant = 1'b0;
  logic cqPush, relReq;
  logic relAck = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  txDmaSeq u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .autoRelease(autoRelease),
    .qNotEmpty(qNotEmpty), .qHeadPkt(qHeadPkt), .qPop(qPop),
    .macStart(macStart), .macRdReq(macRdReq), .macRdAck(macRdAck),
    .macColl(macColl), .macDone(macDone), .macOk(macOk),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memPkt(memPkt), .memGrant(memGrant), .cqPush(cqPush), .cqPkt(cqPkt),
    .relReq(relReq), .relPkt(relPkt), .relAck(relAck)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // One complete frame: nColl collisions, then completion or exhaustion.
  task automatic runTx(input int pkt, input int nColl, input int fixedReads,
                       input bit ok, input bit autoRel);
    bit xs;
    bit finalOk;
    int tries;
    logic [DATA_W-1:0] expStatus;
    xs      = (nColl >= 16);
    finalOk = xs ? 1'b0 : ok;
    tries   = xs ? 16 : nColl + 1;
    @(negedge clk);
    qHeadPkt    = PKT_W'(pkt);
    qNotEmpty   = 1'b1;
    autoRelease = autoRel;
    for (int a = 1; a <= tries; a++) begin
      while (!macStart) @(negedge clk);
      chk(macStart == 1'b1, "R4", "attempt start", macStart, 1);
      qHeadPkt = PKT_W'(pkt) ^ 6'h2A;  // R8: head changes after capture
      @(negedge clk);
      for (int k = 0; k < ((fixedReads > 0) ? fixedReads : (a % 3) + 1); k++) begin
        macRdReq = 1'b1;
        @(negedge clk);
        for (int d = 0; d < (k + a) % 3; d++) begin
          chk(memReq == 1'b1 && macRdAck == 1'b0, "R3", "request held",
              memReq, 1);
          @(negedge clk);
        end
        chk(memReq == 1'b1 && memWe == 1'b0, "R3", "read request", memWe, 0);
        chk(memAddr == ADDR_W'(4 + 2 * k), "R2", "read address",
            memAddr, (4 + 2 * k) % 2048);
        chk(memPkt == PKT_W'(pkt), "R8", "memPkt", memPkt, pkt);
        memGrant = 1'b1;
        #0;
        chk(macRdAck == 1'b1, "R3", "read ack with grant", macRdAck, 1);
        @(negedge clk);
        memGrant = 1'b0;
        macRdReq = 1'b0;
      end
      if (a <= nColl) begin
        macColl = 1'b1;
        @(negedge clk);
        macColl = 1'b0;
      end else begin
        macDone = 1'b1;
        macOk   = ok;
        @(negedge clk);
        macDone = 1'b0;
        macOk   = 1'b0;
      end
    end
    expStatus = '0;
    expStatus[15] = finalOk;
    expStatus[14] = xs;
    expStatus[4:0] = 5'(tries);
    chk(memReq == 1'b1 && memWe == 1'b1, "R5", "status write request", memWe, 1);
    chk(memAddr == '0, "R5", "status address", memAddr, 0);
    chk(memWdata == expStatus, (ok || xs) ? "R5" : "R9", "status word",
        memWdata, expStatus);
    chk(memPkt == PKT_W'(pkt), "R8", "status memPkt", memPkt, pkt);
    chk(macStart == 1'b0, "R4", "no restart after end", macStart, 0);
    memGrant = 1'b1;
    @(negedge clk);
    memGrant = 1'b0;
    if (autoRel && finalOk) begin
      chk(relReq == 1'b1 && relPkt == PKT_W'(pkt), "R6", "release request",
          relPkt, pkt);
      chk(cqPush == 1'b0 && qPop == 1'b0, "R6", "no push before ack", cqPush, 0);
      @(negedge clk);
      chk(relReq == 1'b1, "R6", "release held", relReq, 1);
      relAck = 1'b1;
      #0;
      chk(qPop == 1'b1 && cqPush == 1'b0, "R6", "pop on ack, no push", qPop, 1);
      @(negedge clk);
      relAck    = 1'b0;
      qNotEmpty = 1'b0;
      chk(relReq == 1'b0 && cqPush == 1'b0, "R6", "release done", relReq, 0);
    end else begin
      chk(cqPush == 1'b1 && qPop == 1'b1, autoRel ? "R9" : "R7",
          "push with pop", cqPush, 1);
      chk(cqPkt == PKT_W'(pkt), "R7", "completion pkt", cqPkt, pkt);
      chk(relReq == 1'b0, "R7", "no release", relReq, 0);
      @(negedge clk);
      qNotEmpty = 1'b0;
      chk(cqPush == 1'b0 && qPop == 1'b0, "R7", "single-cycle push", cqPush, 0);
    end
    @(negedge clk);
    chk(macStart == 1'b0 && memReq == 1'b0, "R1", "idle after frame", macStart, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(macStart == 0 && memReq == 0 && qPop == 0 && cqPush == 0 && relReq == 0,
        "R1", "reset state", {macStart, memReq, qPop, cqPush, relReq}, 0);

    // R1: queue full but transmit disabled
    txEnable  = 1'b0;
    qNotEmpty = 1'b1;
    qHeadPkt  = 6'd9;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(macStart == 0 && memReq == 0, "R1", "disabled stays idle", macStart, 0);
    end
    // R1: enabled but queue empty
    qNotEmpty = 1'b0;
    txEnable  = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(macStart == 0 && memReq == 0, "R1", "empty stays idle", macStart, 0);
    end

    for (int c = 0; c <= 16; c++)
      for (int ar = 0; ar < 2; ar++)
        for (int ok = 0; ok < 2; ok++)
          runTx((c * 4 + ar * 2 + ok + 1) % 64, c, 0, 1'(ok), 1'(ar));

    // R2: long frame wraps the 11-bit address counter
    runTx(37, 0, 1100, 1'b1, 1'b0);
    // R4: retry, then a long attempt with wrap, auto-release
    runTx(50, 2, 1030, 1'b1, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule